// File: doc/BRIEF.md
# Auto-Restart and Shutdown Supervisor

This block sequences a self-biased switching regulator controller through its power states. It has no view of analog values. It sees three comparator flags on the supply capacitor: above the upper threshold, below the lower threshold, and below the power-up reset level. It also sees two fault flags: an overvoltage trigger pulse and an over-temperature level. From these it drives two registered enables. One enables the high-voltage start-up charging source. The other enables the PWM output stage.

After power-up the capacitor charges until it first reaches the upper threshold, and then switching begins. If regulation is lost, the capacitor sags to the lower threshold. The block then enters a hysteretic restart mode. In this mode the charging source holds the capacitor inside the threshold window, and the output stays off for a fixed number of charge-discharge cycles. A fault forces a latched off state. The latch keeps the hysteretic supply running, and only a power-up reset clears it.

Top module: `restart_supervisor`

## Requirements
- R1: After `rst`, `charge_en` is 1 and `pwm_en` is 0.
- R2: In the start-up state the outputs keep charge on and PWM off until the first rising edge of `cap_above_hi`. That edge turns charge off and PWM on.
- R3: During normal switching `charge_en` stays 0, and further rising edges of `cap_above_hi` change neither output. The two enables are never 1 together.
- R4: In normal switching, a rising edge of `cap_below_lo` sets `pwm_en` to 0 and `charge_en` to 1, and enters restart mode.
- R5: In restart mode and in the latched state, a rising edge of `cap_below_lo` sets `charge_en` to 1 and a rising edge of `cap_above_hi` sets it to 0. A level held high is counted as one edge.
- R6: In restart mode, `pwm_en` comes back only on the SKIP_CYCLES-th (default 8) rising edge of `cap_above_hi` after restart mode was entered. On that edge `charge_en` goes to 0 and `pwm_en` to 1. All earlier edges leave `pwm_en` at 0.
- R7: Each new entry into restart mode starts the cycle count from zero.
- R8: While `cap_below_por` is low, a high level on `ovp_trig` or `over_temp` enters the latched state. In the latched state `pwm_en` is 0 and stays 0 through any number of threshold cycles.
- R9: A high level on `cap_below_por` puts the block in the start-up state, with `charge_en` 1 and `pwm_en` 0, and clears both the latch and the cycle count. After the reset ends, start-up proceeds as in R2.
- R10: `cap_below_por` takes priority over the fault flags. The fault flags take priority over threshold edges.
- R11: Each input passes through a two-flop synchronizer. An output responds within three clock edges of an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_above_hi | input | 1 | Async: supply capacitor above upper threshold |
| cap_below_lo | input | 1 | Async: supply capacitor below lower threshold |
| cap_below_por | input | 1 | Async: supply below power-up reset level |
| ovp_trig | input | 1 | Async: overvoltage trigger pulse |
| over_temp | input | 1 | Async: over-temperature flag |
| charge_en | output | 1 | Enable for the high-voltage charging source |
| pwm_en | output | 1 | Enable for the PWM output stage |

## Verification
The assertions assume that every input level lasts at least two clock cycles, so that the synchronizers cannot miss it. They also assume that the two threshold flags are never high together, since the capacitor cannot be above the upper threshold and below the lower one at once. The bench models the capacitor voltage with three states (above, in the window, below), so the two flags are never driven high together. It holds each level, fault pulses included, for several cycles. It samples the outputs five cycles after each change, which is longer than the three-edge response time.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    ST_START   = 2'd0,
    ST_RUN     = 2'd1,
    ST_RESTART = 2'd2,
    ST_LATCH   = 2'd3
  } supv_state_e;
endpackage

// File: rtl/supv_sync.sv
// Two-flop synchronizer per bit plus a third flop for rising-edge detection.
module supv_sync #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic q1, q2, q3;
    always_ff @(posedge clk) begin
      if (rst) begin
        q1 <= 1'b0;
        q2 <= 1'b0;
        q3 <= 1'b0;
      end else begin
        q1 <= async_in[b];
        q2 <= q1;
        q3 <= q2;
      end
    end
    assign lvl[b]  = q2;
    assign rise[b] = q2 & ~q3;
  end
endmodule

// File: rtl/supv_skip_cnt.sv
// Counts upper-threshold arrivals during restart; flags the last one.
module supv_skip_cnt #(
  parameter int CYCLES = 8,
  localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == W'(CYCLES - 1));

  // R6: the controller must never step past the final count
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (rst)
    step |-> (cnt != W'(CYCLES - 1)));
endmodule

// File: rtl/restart_supervisor.sv
module restart_supervisor
  import supv_pkg::*;
#(
  parameter int SKIP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic cap_above_hi,
  input  logic cap_below_lo,
  input  logic cap_below_por,
  input  logic ovp_trig,
  input  logic over_temp,
  output logic charge_en,
  output logic pwm_en
);
  localparam int NIN   = 5;
  localparam int B_HI  = 0;
  localparam int B_LO  = 1;
  localparam int B_POR = 2;
  localparam int B_OVP = 3;
  localparam int B_OTP = 4;

  logic [NIN-1:0] s_lvl, s_rise;
  logic hi_rise, lo_rise, por_lvl, fault_lvl, last, step;
  supv_state_e st, st_n;
  logic chg_n, pwm_n;

  supv_sync #(.N(NIN)) i_sync (
    .clk(clk), .rst(rst),
    .async_in({over_temp, ovp_trig, cap_below_por, cap_below_lo, cap_above_hi}),
    .lvl(s_lvl), .rise(s_rise)
  );

  assign hi_rise   = s_rise[B_HI];
  assign lo_rise   = s_rise[B_LO];
  assign por_lvl   = s_lvl[B_POR];
  assign fault_lvl = s_lvl[B_OVP] | s_lvl[B_OTP];

  assign step = (st == ST_RESTART) && !por_lvl && !fault_lvl && hi_rise && !last;

  supv_skip_cnt #(.CYCLES(SKIP_CYCLES)) i_cnt (
    .clk(clk), .rst(rst),
    .clr(st != ST_RESTART),
    .step(step),
    .last(last)
  );

  always_comb begin
    st_n  = st;
    chg_n = charge_en;
    pwm_n = pwm_en;
    if (por_lvl) begin
      st_n  = ST_START;
      chg_n = 1'b1;
      pwm_n = 1'b0;
    end else if (fault_lvl) begin
      st_n  = ST_LATCH;
      pwm_n = 1'b0;
      if (lo_rise)      chg_n = 1'b1;
      else if (hi_rise) chg_n = 1'b0;
    end else begin
      case (st)
        ST_START: begin
          if (hi_rise) begin
            st_n  = ST_RUN;
            chg_n = 1'b0;
            pwm_n = 1'b1;
          end
        end
        ST_RUN: begin
          if (lo_rise) begin
            st_n  = ST_RESTART;
            chg_n = 1'b1;
            pwm_n = 1'b0;
          end
        end
        ST_RESTART: begin
          if (hi_rise) begin
            chg_n = 1'b0;
            if (last) begin
              st_n  = ST_RUN;
              pwm_n = 1'b1;
            end
          end else if (lo_rise) begin
            chg_n = 1'b1;
          end
        end
        default: begin
          pwm_n = 1'b0;
          if (lo_rise)      chg_n = 1'b1;
          else if (hi_rise) chg_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_START;
      charge_en <= 1'b1;
      pwm_en    <= 1'b0;
    end else begin
      st        <= st_n;
      charge_en <= chg_n;
      pwm_en    <= pwm_n;
    end
  end

  // R3: charging and switching are never enabled together
  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(charge_en && pwm_en));

  // R2, R6: switching only begins in response to an upper-threshold arrival
  a_r6_pwm_needs_hi: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_en) |-> $past(hi_rise));

  // R9: power-up reset forces the power-up output defaults
  a_r9_por_defaults: assert property (@(posedge clk) disable iff (rst)
    por_lvl |=> (charge_en && !pwm_en && st == ST_START));

  // R8: the latch is left only through power-up reset
  a_r8_latch_holds: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LATCH && !por_lvl) |=> (st == ST_LATCH && !pwm_en));

  // R10: a fault without power-up reset always turns switching off
  a_r10_fault_off: assert property (@(posedge clk) disable iff (rst)
    (fault_lvl && !por_lvl) |=> !pwm_en);
endmodule

// File: tb/test_restart_supervisor.sv
module test_restart_supervisor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hi = 1'b0, lo = 1'b0, por = 1'b0, ovp = 1'b0, otp = 1'b0;
  logic charge_en, pwm_en;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  restart_supervisor #(.SKIP_CYCLES(8)) i_restart_supervisor (
    .clk(clk), .rst(rst),
    .cap_above_hi(hi), .cap_below_lo(lo), .cap_below_por(por),
    .ovp_trig(ovp), .over_temp(otp),
    .charge_en(charge_en), .pwm_en(pwm_en)
  );

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic expect_out(string req, logic exp_chg, logic exp_pwm);
    total++;
    if (charge_en !== exp_chg || pwm_en !== exp_pwm) begin
      bad++;
      $display("FAIL %s: chg=%b pwm=%b expected chg=%b pwm=%b",
               req, charge_en, pwm_en, exp_chg, exp_pwm);
    end
  endtask

  task automatic v_above();  hi = 1'b1; lo = 1'b0; settle(); endtask
  task automatic v_window(); hi = 1'b0; lo = 1'b0; settle(); endtask
  task automatic v_below();  hi = 1'b0; lo = 1'b1; settle(); endtask

  task automatic do_por();
    v_below();
    por = 1'b1; settle();
    expect_out("R9 por", 1'b1, 1'b0);
    por = 1'b0; v_window();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R1 reset", 1'b1, 1'b0);
  endtask

  task automatic t_startup();
    v_window();
    expect_out("R2 before first hi", 1'b1, 1'b0);
    v_above();
    expect_out("R2 first hi", 1'b0, 1'b1);
    v_window(); v_above();
    expect_out("R3 run ignores hi", 1'b0, 1'b1);
  endtask

  task automatic t_restart();
    v_window(); v_below();
    expect_out("R4 lo in run", 1'b1, 1'b0);
    v_above();
    expect_out("R5 hi in restart", 1'b0, 1'b0);
    v_window(); v_below();
    expect_out("R5 lo in restart", 1'b1, 1'b0);
    for (int k = 2; k <= 7; k++) begin
      v_above();
      expect_out("R6 early hi", 1'b0, 1'b0);
      v_window(); v_below();
    end
    v_above();
    expect_out("R6 eighth hi", 1'b0, 1'b1);
    v_window(); v_below();
    expect_out("R7 second restart", 1'b1, 1'b0);
    v_above();
    expect_out("R7 count cleared", 1'b0, 1'b0);
  endtask

  task automatic t_latch_otp();
    do_por();
    v_above();
    expect_out("R9 restart after por", 1'b0, 1'b1);
    otp = 1'b1; settle(); otp = 1'b0; settle();
    expect_out("R8 otp latch", 1'b0, 1'b0);
    v_window(); v_below();
    expect_out("R5 lo in latch", 1'b1, 1'b0);
    for (int k = 0; k < 9; k++) begin
      v_above(); v_window(); v_below();
    end
    v_above();
    expect_out("R8 latch holds", 1'b0, 1'b0);
  endtask

  task automatic t_latch_ovp();
    do_por();
    v_above();
    ovp = 1'b1; repeat (3) @(negedge clk); ovp = 1'b0; settle();
    expect_out("R8 ovp latch", 1'b0, 1'b0);
  endtask

  task automatic t_priority();
    v_below();
    por = 1'b1; otp = 1'b1; settle();
    expect_out("R10 por over fault", 1'b1, 1'b0);
    por = 1'b0; settle();
    v_above();
    expect_out("R10 fault over hi", 1'b0, 1'b0);
    otp = 1'b0;
    do_por();
    v_above();
    expect_out("R9 latch cleared", 1'b0, 1'b1);
  endtask

  task automatic t_latency();
    v_window(); v_below();
    repeat (3) @(negedge clk);
    hi = 1'b0;
    expect_out("R11 restart state", 1'b1, 1'b0);
    hi = 1'b1; lo = 1'b0;
    repeat (4) @(negedge clk);
    expect_out("R11 within three edges", 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_restart();
    t_latch_otp();
    t_latch_ovp();
    t_priority();
    t_latency();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule